// File: doc/BRIEF.md
# Serial-Wire Debug Target Responder

This block is the target end of a two-wire serial debug link. It runs entirely on the serial clock and samples the host's data line on every rising edge. It follows the line through three conditions. A long run of high samples puts it into line reset. A short run of low samples then brings it to idle. In idle it accepts transactions. Each transaction is an 8-bit request from the host, a 3-bit acknowledge from the target, and a 33-bit data phase in whichever direction the request selects. A one-cycle turnaround, with neither side driving, separates each change of direction.

Behind the link sits a small register set with four word addresses. Address 0 reads back a fixed identification word, and a write there can clear the error flag. Address 1 reports a sticky write-parity error flag. Addresses 2 and 3 are general read/write words. Every write that arrives intact is also shown on a one-cycle strobe with its address and data, so nearby logic can act on it. After any line reset the target stays locked. Until the identification word has been read, every other access is refused with a FAULT acknowledge.

Top module: `swd_target`

## Requirements
- R1: More than RST_LEN (default 50) consecutive high samples, counted only while the host owns the line, put the target into line reset and abort any transfer in progress; exactly RST_LEN high samples do not; swd_oe stays low throughout line reset.
- R2: After power-on reset or line reset, no request is accepted until IDLE_LEN (default 2) consecutive low samples have been seen; a single low sample followed by high samples is not enough.
- R3: A request is 8 bits, sent first bit first: start (1), port select, read-not-write, address bit 0, address bit 1, even parity over the four preceding fields, stop (0), park (1); a request with a bad stop, park or parity bit gets no response, and the target returns to waiting for a start bit.
- R4: A valid request is followed by exactly one undriven turnaround cycle and then 3 acknowledge bits sent bit 0 first, with OK encoded 3'b001 and FAULT encoded 3'b100; no WAIT is ever returned.
- R5: From reset until a read of address 0 is acknowledged OK, every other access gets FAULT and has no effect, so no write strobe is produced.
- R6: An OK read drives 32 data bits LSB first, then one even-parity bit over them, then releases the line for one turnaround cycle.
- R7: A read of address 0 returns the ID_VALUE parameter.
- R8: An OK write takes one turnaround cycle, then 32 data bits LSB first and an even-parity bit from the host; with correct parity, bus_stb is high for exactly one cycle, starting the cycle after the parity bit, carrying the address and data, and addresses 2 and 3 then read back the written word.
- R9: Write data with a parity error is discarded, so there is no strobe and no register change, and the flag at address 1 bit 0 is set; writing address 0 with bit 0 set clears that flag.
- R10: A request with the port-select bit set is answered FAULT and has no data phase.
- R11: swd_oe is low in reset, in every turnaround cycle, and at all times other than the acknowledge and read-data bits; bus_stb is low in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial debug clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| swd_di | input | 1 | Data line as seen by the target |
| swd_do | output | 1 | Data the target drives onto the line |
| swd_oe | output | 1 | High while the target drives the line |
| bus_stb | output | 1 | One-cycle pulse for each accepted write |
| bus_addr | output | 2 | Word address of the accepted write |
| bus_wdata | output | DW | Data of the accepted write |

## Verification
The hardest conditions to reach are the edges of the line-state tracker. Each needs a precise run length, and each is hidden behind request parsing that keeps running on the same bits. The bench drives a run of exactly 50 high samples and then a run of 51. After each run it sends a read of a general register, and the acknowledge shows whether the lock was re-armed. It also follows a line reset with one low sample and then a full request. The only evidence it can use is a line that stays undriven, so it checks the enable for many cycles before the proper two-low entry into idle and the identification read that unlocks the target.

// File: rtl/swdt_pkg.sv
package swdt_pkg;

  typedef enum logic [2:0] {
    PH_LISTEN,
    PH_REQ,
    PH_TRN1,
    PH_ACK,
    PH_RDATA,
    PH_TRNO,
    PH_TRNW,
    PH_WDATA
  } phase_t;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  localparam int REQ_BITS = 8;

  typedef struct packed {
    logic       valid;
    logic       ap;
    logic       rnw;
    logic [1:0] addr;
  } req_t;

endpackage

// File: rtl/swdt_line_mon.sv
module swdt_line_mon #(
  parameter int RST_LEN  = 50,
  parameter int IDLE_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic host,
  input  logic di,
  output logic hit,
  output logic idle,
  output logic in_reset
);
  localparam int OW = $clog2(RST_LEN + 2);
  localparam int ZW = $clog2(IDLE_LEN + 1);

  logic [OW-1:0] ones;
  logic [ZW-1:0] zc;
  logic          in_rst_q;

  assign hit      = host && di && (ones == OW'(RST_LEN));
  assign in_reset = in_rst_q;
  assign idle     = !in_rst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ones     <= '0;
      zc       <= '0;
      in_rst_q <= 1'b1;
    end else begin
      if (!host || !di)
        ones <= '0;
      else if (ones != OW'(RST_LEN + 1))
        ones <= ones + 1'b1;

      if (hit) begin
        in_rst_q <= 1'b1;
        zc       <= '0;
      end else if (in_rst_q && host) begin
        if (di)
          zc <= '0;
        else if (zc == ZW'(IDLE_LEN - 1)) begin
          in_rst_q <= 1'b0;
          zc       <= '0;
        end else
          zc <= zc + 1'b1;
      end
    end
  end

  // R2: leaving line reset is always caused by a low sample
  p_idle_from_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(idle) |-> ($past(di) == 1'b0))
    else $error("idle entered without a low sample");

endmodule

// File: rtl/swdt_req_dec.sv
module swdt_req_dec
  import swdt_pkg::*;
(
  input  logic [REQ_BITS-1:0] bits,
  output req_t                rq
);
  always_comb begin
    rq.ap    = bits[1];
    rq.rnw   = bits[2];
    rq.addr  = bits[4:3];
    rq.valid = bits[0] && !bits[6] && bits[7] && ((^bits[4:1]) == bits[5]);
  end
endmodule

// File: rtl/swdt_regs.sv
module swdt_regs #(
  parameter int             DW       = 32,
  parameter logic [DW-1:0]  ID_VALUE = 32'h4C7E_0A31,
  parameter int             NSCR     = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          perr,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] scr [NSCR];
  logic          sticky;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSCR; i++) begin
      if (rst)
        scr[i] <= '0;
      else if (wr_en && wr_addr == 2'(i + 2))
        scr[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      sticky <= 1'b0;
    else if (perr)
      sticky <= 1'b1;
    else if (wr_en && wr_addr == 2'd0 && wr_data[0])
      sticky <= 1'b0;
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = ID_VALUE;
      2'd1:    rd_data = {{(DW-1){1'b0}}, sticky};
      2'd2:    rd_data = scr[0];
      default: rd_data = scr[NSCR-1];
    endcase
  end

  // R9: a parity-failed write never changes a general register
  p_perr_no_write_r9: assert property (@(posedge clk) disable iff (rst)
    perr |=> $stable(scr[0]) && $stable(scr[NSCR-1]))
    else $error("discarded write changed storage");

endmodule

// File: rtl/swd_target.sv
module swd_target
  import swdt_pkg::*;
#(
  parameter int            DW       = 32,
  parameter logic [DW-1:0] ID_VALUE = 32'h4C7E_0A31,
  parameter int            RST_LEN  = 50,
  parameter int            IDLE_LEN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          swd_di,
  output logic          swd_do,
  output logic          swd_oe,
  output logic          bus_stb,
  output logic [1:0]    bus_addr,
  output logic [DW-1:0] bus_wdata
);
  localparam int DCNT = DW + 1;
  localparam int CW   = $clog2(DCNT + 1);

  phase_t                phase;
  logic [CW-1:0]         cnt;
  logic [REQ_BITS-2:0]   req_sr;
  logic [REQ_BITS-1:0]   req_full;
  req_t                  rq;
  logic                  id_ok;
  logic [2:0]            ack_q;
  logic                  rnw_q;
  logic [1:0]            addr_q;
  logic [DW:0]           dsr;
  logic                  host_phase, ln_hit, ln_idle, ln_reset;
  logic [DW-1:0]         rd_val;
  logic                  wr_go, wr_perr, acc_ok;

  assign req_full   = {swd_di, req_sr};
  assign host_phase = (phase == PH_LISTEN) || (phase == PH_REQ) || (phase == PH_WDATA);
  assign acc_ok     = !rq.ap && (id_ok || (rq.rnw && rq.addr == 2'd0));
  assign wr_go      = !ln_hit && phase == PH_WDATA && cnt == CW'(DW) &&
                      ((^dsr[DW-1:0]) == swd_di);
  assign wr_perr    = !ln_hit && phase == PH_WDATA && cnt == CW'(DW) &&
                      ((^dsr[DW-1:0]) != swd_di);

  swdt_line_mon #(.RST_LEN(RST_LEN), .IDLE_LEN(IDLE_LEN)) u_line (
    .clk(clk), .rst(rst), .host(host_phase), .di(swd_di),
    .hit(ln_hit), .idle(ln_idle), .in_reset(ln_reset)
  );

  swdt_req_dec u_dec (.bits(req_full), .rq(rq));

  swdt_regs #(.DW(DW), .ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_go), .wr_addr(addr_q),
    .wr_data(dsr[DW-1:0]), .perr(wr_perr), .rd_addr(rq.addr), .rd_data(rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_LISTEN;
      cnt       <= '0;
      req_sr    <= '0;
      id_ok     <= 1'b0;
      ack_q     <= '0;
      rnw_q     <= 1'b0;
      addr_q    <= '0;
      dsr       <= '0;
      swd_do    <= 1'b0;
      swd_oe    <= 1'b0;
      bus_stb   <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      bus_stb <= wr_go;
      if (wr_go) begin
        bus_addr  <= addr_q;
        bus_wdata <= dsr[DW-1:0];
      end
      if (ln_hit) begin
        phase  <= PH_LISTEN;
        cnt    <= '0;
        id_ok  <= 1'b0;
        swd_oe <= 1'b0;
        swd_do <= 1'b0;
      end else begin
        case (phase)
          PH_LISTEN: if (ln_idle && swd_di) begin
            req_sr <= {1'b1, {(REQ_BITS-2){1'b0}}};
            phase  <= PH_REQ;
            cnt    <= '0;
          end
          PH_REQ: begin
            req_sr <= req_full[REQ_BITS-1:1];
            if (cnt == CW'(REQ_BITS - 2)) begin
              cnt <= '0;
              if (rq.valid) begin
                phase  <= PH_TRN1;
                rnw_q  <= rq.rnw;
                addr_q <= rq.addr;
                ack_q  <= acc_ok ? ACK_OK : ACK_FAULT;
                if (acc_ok && rq.rnw) dsr <= {^rd_val, rd_val};
                if (acc_ok && rq.rnw && rq.addr == 2'd0) id_ok <= 1'b1;
              end else
                phase <= PH_LISTEN;
            end else
              cnt <= cnt + 1'b1;
          end
          PH_TRN1: begin
            phase  <= PH_ACK;
            swd_do <= ack_q[0];
            swd_oe <= 1'b1;
            cnt    <= CW'(1);
          end
          PH_ACK: begin
            if (cnt < CW'(3)) begin
              swd_do <= ack_q[cnt[1:0]];
              cnt    <= cnt + 1'b1;
            end else if (ack_q == ACK_OK && rnw_q) begin
              phase  <= PH_RDATA;
              swd_do <= dsr[0];
              dsr    <= dsr >> 1;
              cnt    <= CW'(1);
            end else begin
              swd_oe <= 1'b0;
              swd_do <= 1'b0;
              cnt    <= '0;
              phase  <= (ack_q == ACK_OK) ? PH_TRNW : PH_TRNO;
            end
          end
          PH_RDATA: begin
            if (cnt < CW'(DCNT)) begin
              swd_do <= dsr[0];
              dsr    <= dsr >> 1;
              cnt    <= cnt + 1'b1;
            end else begin
              swd_oe <= 1'b0;
              swd_do <= 1'b0;
              phase  <= PH_TRNO;
            end
          end
          PH_TRNO: phase <= PH_LISTEN;
          PH_TRNW: begin
            phase <= PH_WDATA;
            cnt   <= '0;
          end
          PH_WDATA: begin
            if (cnt < CW'(DW)) begin
              dsr[DW-1:0] <= {swd_di, dsr[DW-1:1]};
              cnt         <= cnt + 1'b1;
            end else begin
              phase <= PH_LISTEN;
              cnt   <= '0;
            end
          end
          default: phase <= PH_LISTEN;
        endcase
      end
    end
  end

  // R1: the target never drives while the line is in reset
  p_quiet_in_reset_r1: assert property (@(posedge clk) disable iff (rst)
    ln_reset |-> !swd_oe)
    else $error("driving during line reset");

  // R4: driving always starts right after the first turnaround cycle
  p_drive_after_turn_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(swd_oe) |-> ($past(phase) == PH_TRN1))
    else $error("drive began without turnaround");

  // R11: turnaround cycles are undriven
  p_turn_undriven_r11: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_TRN1 || phase == PH_TRNO || phase == PH_TRNW) |-> !swd_oe)
    else $error("driven in turnaround");

  // R5: no write reaches the bus while locked
  p_locked_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> id_ok)
    else $error("write strobe while locked");

  // R8: strobe is a single-cycle pulse
  p_stb_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    bus_stb |=> !bus_stb)
    else $error("strobe longer than one cycle");

endmodule

// File: tb/sim_swd_target.sv
module sim_swd_target;
  localparam logic [31:0] ID = 32'h4C7E_0A31;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        di  = 1'b0;
  logic        sdo, soe, stb;
  logic [1:0]  baddr;
  logic [31:0] bdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  bit          unlocked = 1'b0;
  logic        sticky   = 1'b0;
  logic [31:0] scr2 = '0, scr3 = '0;

  typedef struct { logic [1:0] a; logic [31:0] d; } wexp_t;
  wexp_t wq[$];

  always #5 clk = ~clk;

  swd_target #(.DW(32), .ID_VALUE(ID), .RST_LEN(50), .IDLE_LEN(2)) u0 (
    .clk(clk), .rst(rst), .swd_di(di), .swd_do(sdo), .swd_oe(soe),
    .bus_stb(stb), .bus_addr(baddr), .bus_wdata(bdata)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); di = 1'b0; end
  endtask

  task automatic line_run(input int n);
    repeat (n) begin @(negedge clk); di = 1'b1; end
    if (n > 50) unlocked = 1'b0;
  endtask

  // corrupt: 0 none, 1 request parity, 2 stop bit, 3 park bit
  task automatic xfer(input bit ap, input bit rnw, input logic [1:0] a,
                      input logic [31:0] wd, input int corrupt, input bit bad_wpar,
                      input string tag);
    logic [7:0]  r;
    logic [2:0]  got;
    logic [32:0] dat;
    logic [31:0] expv;
    bit          ok, oe_all;
    r[0] = 1'b1; r[1] = ap; r[2] = rnw; r[3] = a[0]; r[4] = a[1];
    r[5] = ap ^ rnw ^ a[0] ^ a[1] ^ (corrupt == 1);
    r[6] = (corrupt == 2);
    r[7] = !(corrupt == 3);
    for (int i = 0; i < 8; i++) begin @(negedge clk); di = r[i]; end
    @(negedge clk); di = 1'b0;
    chk({tag, " R4 turnaround undriven"}, 64'(soe), 64'd0);
    if (corrupt != 0) begin
      oe_all = 1'b0;
      repeat (6) begin @(negedge clk); oe_all = oe_all | soe; end
      chk({tag, " R3 bad request gets no response"}, 64'(oe_all), 64'd0);
      return;
    end
    ok = !ap && (unlocked || (rnw && a == 2'd0));
    oe_all = 1'b1;
    for (int k = 0; k < 3; k++) begin @(negedge clk); got[k] = sdo; oe_all &= soe; end
    chk({tag, " R11 ack driven"}, 64'(oe_all), 64'd1);
    chk({tag, " R4 ack code"}, 64'(got), ok ? 64'(3'b001) : 64'(3'b100));
    if (!ok) begin
      @(negedge clk);
      chk({tag, " R10 no data phase after FAULT"}, 64'(soe), 64'd0);
      return;
    end
    if (rnw) begin
      case (a)
        2'd0: expv = ID;
        2'd1: expv = {31'd0, sticky};
        2'd2: expv = scr2;
        default: expv = scr3;
      endcase
      if (a == 2'd0) unlocked = 1'b1;
      oe_all = 1'b1;
      for (int k = 0; k < 33; k++) begin @(negedge clk); dat[k] = sdo; oe_all &= soe; end
      chk({tag, " R6 read data"}, 64'(dat[31:0]), 64'(expv));
      chk({tag, " R6 read parity"}, 64'(dat[32]), 64'(^expv));
      chk({tag, " R11 read driven"}, 64'(oe_all), 64'd1);
      @(negedge clk);
      chk({tag, " R6 trailing turnaround"}, 64'(soe), 64'd0);
    end else begin
      @(negedge clk); di = 1'b0;
      chk({tag, " R11 write turnaround undriven"}, 64'(soe), 64'd0);
      for (int k = 0; k < 32; k++) begin @(negedge clk); di = wd[k]; end
      @(negedge clk); di = (^wd) ^ bad_wpar;
      if (!bad_wpar) begin
        wq.push_back('{a: a, d: wd});
        if (a == 2'd0 && wd[0]) sticky = 1'b0;
        if (a == 2'd2) scr2 = wd;
        if (a == 2'd3) scr3 = wd;
      end else
        sticky = 1'b1;
      @(negedge clk); di = 1'b0;
      chk({tag, bad_wpar ? " R9 no strobe" : " R8 strobe timing"}, 64'(stb), 64'(!bad_wpar));
    end
  endtask

  // monitor: every strobe must match the next expected write
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && stb) begin
        if (wq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5/R9 unexpected strobe actual addr=%h data=%h expected none", baddr, bdata);
        end else begin
          wexp_t e;
          e = wq.pop_front();
          chk("R8 strobe addr", 64'(baddr), 64'(e.a));
          chk("R8 strobe data", 64'(bdata), 64'(e.d));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R11 reset oe", 64'(soe), 64'd0);
    chk("R11 reset strobe", 64'(stb), 64'd0);
    rst = 1'b0;
    idle(2);
    // locked after power-on
    xfer(0, 0, 2'd2, 32'hDEAD_0001, 0, 0, "locked write R5");
    xfer(0, 1, 2'd2, 32'h0, 0, 0, "locked read R5");
    xfer(0, 1, 2'd0, 32'h0, 0, 0, "ID read R7");
    idle(1);
    xfer(0, 0, 2'd2, 32'hA5A5_1234, 0, 0, "write a2 R8");
    xfer(0, 1, 2'd2, 32'h0, 0, 0, "readback a2 R8");
    xfer(0, 0, 2'd3, 32'h0F0F_7777, 0, 1, "bad wpar R9");
    xfer(0, 1, 2'd3, 32'h0, 0, 0, "a3 unchanged R9");
    xfer(0, 1, 2'd1, 32'h0, 0, 0, "sticky set R9");
    xfer(0, 0, 2'd0, 32'h0000_0001, 0, 0, "clear sticky R9");
    xfer(0, 1, 2'd1, 32'h0, 0, 0, "sticky clear R9");
    xfer(0, 0, 2'd3, 32'hFFFF_FFFF, 0, 0, "all ones write R8");
    xfer(0, 1, 2'd3, 32'h0, 0, 0, "all ones read R6");
    xfer(0, 1, 2'd2, 32'h0, 1, 0, "req parity R3");
    xfer(0, 1, 2'd2, 32'h0, 2, 0, "req stop R3");
    xfer(0, 0, 2'd2, 32'h1111_2222, 3, 0, "req park R3");
    xfer(0, 1, 2'd2, 32'h0, 0, 0, "state kept R3");
    xfer(1, 1, 2'd0, 32'h0, 0, 0, "port select R10");
    // exactly RST_LEN high samples: still unlocked
    line_run(50); idle(10);
    xfer(0, 1, 2'd2, 32'h0, 0, 0, "50 ones R1");
    // one more high sample: line reset, locked again
    line_run(51); idle(2);
    xfer(0, 1, 2'd3, 32'h0, 0, 0, "after line reset R1 R5");
    xfer(0, 0, 2'd2, 32'h3333_4444, 0, 0, "locked write R5");
    xfer(0, 1, 2'd0, 32'h0, 0, 0, "unlock R7");
    xfer(0, 1, 2'd2, 32'h0, 0, 0, "a2 survives R5");
    // single low sample is not enough to reach idle
    line_run(60);
    idle(1);
    begin
      logic [7:0] rr;
      bit         oe_any;
      rr = 8'b1010_0101;
      for (int i = 0; i < 8; i++) begin @(negedge clk); di = rr[i]; end
      oe_any = 1'b0;
      repeat (16) begin @(negedge clk); di = 1'b0; oe_any = oe_any | soe; end
      chk("R2 single low sample no response", 64'(oe_any), 64'd0);
    end
    xfer(0, 1, 2'd0, 32'h0, 0, 0, "ID after idle R2");
    xfer(0, 1, 2'd1, 32'h0, 0, 0, "status R9");
    idle(4);
    chk("R8 no pending writes", 64'(wq.size()), 64'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule